// File: doc/BRIEF.md
# SPI Frame Clock Monitor and SDI Stuck-Line Detector

This block sits beside a serial peripheral port and judges each chip-select frame once it has ended. While the active-low select is held low it counts every transition of the serial clock, both rising and falling. It also watches the data-in bits taken on rising clock edges. When select goes high again, it compares the transition count with the frame length chosen by a width code. It also checks whether the received bits were all zeros or all ones, which is what a data line shorted to ground or to supply would give. It then emits one of three single-cycle verdicts: frame accepted, length error, or stuck-line fail-safe.

The block also drives a level flag that tells the output shifter when the frame has run past its configured length, so that the shifter can put zeros on the line instead of stale data. A sticky length-error flag records that the last clocked frame had the wrong length. The next frame of correct length clears it. All inputs are assumed to be already synchronised to the system clock. The serial clock must be sampled at least once per half period.

Top module: `spi_frame_monitor`

## Requirements
- R1: The width code selects the frame length: 3'b001 means 16 clock periods, 3'b010 means 24 and 3'b100 means 32. A frame with exactly twice that many serial-clock transitions while select is low, and with mixed data bits, gives a `frame_ok` pulse.
- R2: A frame with at least one transition but a count different from twice the configured length gives a `comm_err` pulse and no `frame_ok`.
- R3: If at least one bit was sampled and every bit sampled on a rising clock edge was 0, or every bit was 1, the frame gives a `fail_safe` pulse and no `frame_ok`. This holds whatever the frame length.
- R4: Holding select low with no clock transitions gives no pulse of any kind and leaves `len_err_flag` unchanged.
- R5: Verdict pulses last exactly one system-clock cycle. They appear in the cycle right after the first clock edge at which select is sampled high following a low period, and at no other time.
- R6: `pad_zero` is high while select is low and the transition count has reached twice the configured length. It is low at every earlier point in the frame and while select is high.
- R7: `len_err_flag` is set together with any `comm_err` pulse. It is cleared by the next clocked frame whose count matches, even if that frame is stuck.
- R8: A width code other than the three listed makes every clocked frame a length error, and `pad_zero` never rises.
- R9: The transition counter saturates instead of wrapping. A very long frame, such as 96 periods at the 32-period setting, is still a length error.
- R10: While reset is asserted and immediately after it, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Synchronised serial clock |
| csn | input | 1 | Synchronised active-low chip select |
| sdi | input | 1 | Synchronised serial data in |
| width_code | input | 3 | Frame length selector (one-hot: 16/24/32 periods) |
| frame_ok | output | 1 | Pulse: frame length correct and data not stuck |
| comm_err | output | 1 | Pulse: transition count mismatch |
| fail_safe | output | 1 | Pulse: all data bits identical |
| len_err_flag | output | 1 | Sticky: last clocked frame had the wrong length |
| pad_zero | output | 1 | Level: frame has exceeded its configured length, pad output with zeros |

## Verification
A counter that is off by one transition, or one that wraps, shows up one cycle after select rises: an expected `frame_ok` becomes `comm_err`, or the reverse. A long frame whose count wraps back onto the legal value exposes the wrapping case. The stuck-line trackers need at least one mixed frame and one uniform frame of each polarity, since a tracker stuck in either state flips the verdict only on that pattern. `pad_zero` is checked after every full clock period. An early or late threshold therefore shows within one period of the boundary, long before the frame ends.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

  localparam int unsigned CODE_W   = 3;
  localparam int unsigned PERIOD_W = 8;

  localparam logic [CODE_W-1:0] CODE_P16 = 3'b001;
  localparam logic [CODE_W-1:0] CODE_P24 = 3'b010;
  localparam logic [CODE_W-1:0] CODE_P32 = 3'b100;

  localparam logic [PERIOD_W-1:0] LEN_P16 = 8'd16;
  localparam logic [PERIOD_W-1:0] LEN_P24 = 8'd24;
  localparam logic [PERIOD_W-1:0] LEN_P32 = 8'd32;

  typedef struct packed {
    logic ok;
    logic len_err;
    logic stuck;
  } verdict_t;

  // Clock periods for a width code; zero marks an unsupported code.
  function automatic logic [PERIOD_W-1:0] periods_for(input logic [CODE_W-1:0] code);
    logic [PERIOD_W-1:0] p;
    unique case (code)
      CODE_P16: p = LEN_P16;
      CODE_P24: p = LEN_P24;
      CODE_P32: p = LEN_P32;
      default:  p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sfm_edge_track.sv
module sfm_edge_track (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic csn,
  output logic sck_edge,
  output logic sck_rise,
  output logic frame_end
);

  logic sck_q, sck_q_n;
  logic csn_q, csn_q_n;

  always_comb begin
    sck_q_n = sck;
    csn_q_n = csn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      csn_q <= 1'b1;
    end else begin
      sck_q <= sck_q_n;
      csn_q <= csn_q_n;
    end
  end

  always_comb begin
    sck_edge  = !csn && (sck != sck_q);
    sck_rise  = !csn && sck && !sck_q;
    frame_end = csn && !csn_q;
  end

endmodule

// File: rtl/sfm_edge_counter.sv
module sfm_edge_counter #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q, count_n;

  always_comb begin
    count_n = count_q;
    if (clear)
      count_n = '0;
    else if (inc && (count_q != CNT_MAX))
      count_n = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_n;
  end

  assign count = count_q;

endmodule

// File: rtl/sfm_sdi_watch.sv
module sfm_sdi_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic sample,
  input  logic sdi,
  output logic all_zero,
  output logic all_one
);

  logic zero_q, zero_n;
  logic one_q, one_n;

  always_comb begin
    zero_n = zero_q;
    one_n  = one_q;
    if (clear) begin
      zero_n = 1'b1;
      one_n  = 1'b1;
    end else if (sample) begin
      zero_n = zero_q && !sdi;
      one_n  = one_q && sdi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_q <= 1'b1;
      one_q  <= 1'b1;
    end else begin
      zero_q <= zero_n;
      one_q  <= one_n;
    end
  end

  assign all_zero = zero_q;
  assign all_one  = one_q;

endmodule

// File: rtl/sfm_frame_judge.sv
module sfm_frame_judge
  import sfm_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] want,
  input  logic             code_valid,
  input  logic             all_zero,
  input  logic             all_one,
  output logic             frame_ok,
  output logic             comm_err,
  output logic             fail_safe,
  output logic             len_err_flag
);

  verdict_t v_q, v_n;
  logic     sticky_q, sticky_n;
  logic     clocked, len_match, stuck;

  always_comb begin
    clocked   = (count != '0);
    len_match = code_valid && (count == want);
    stuck     = clocked && (all_zero || all_one);
    v_n       = '0;
    sticky_n  = sticky_q;
    if (frame_end && clocked) begin
      v_n.ok      = len_match && !stuck;
      v_n.len_err = !len_match;
      v_n.stuck   = stuck;
      sticky_n    = !len_match;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q      <= '0;
      sticky_q <= 1'b0;
    end else begin
      v_q      <= v_n;
      sticky_q <= sticky_n;
    end
  end

  assign frame_ok     = v_q.ok;
  assign comm_err     = v_q.len_err;
  assign fail_safe    = v_q.stuck;
  assign len_err_flag = sticky_q;

endmodule

// File: rtl/spi_frame_monitor.sv
module spi_frame_monitor
  import sfm_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              csn,
  input  logic              sdi,
  input  logic [CODE_W-1:0] width_code,
  output logic              frame_ok,
  output logic              comm_err,
  output logic              fail_safe,
  output logic              len_err_flag,
  output logic              pad_zero
);

  logic                sck_edge, sck_rise, frame_end;
  logic [CNT_W-1:0]    edge_cnt;
  logic                all_zero, all_one;
  logic [PERIOD_W-1:0] periods;
  logic [CNT_W-1:0]    want_edges;
  logic                code_valid;

  always_comb begin
    periods    = periods_for(width_code);
    code_valid = (periods != '0);
    want_edges = CNT_W'({periods, 1'b0});
    pad_zero   = !csn && code_valid && (edge_cnt >= want_edges);
  end

  sfm_edge_track u_edges (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck       (sck),
    .csn       (csn),
    .sck_edge  (sck_edge),
    .sck_rise  (sck_rise),
    .frame_end (frame_end)
  );

  sfm_edge_counter #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (csn),
    .inc   (sck_edge),
    .count (edge_cnt)
  );

  sfm_sdi_watch u_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (csn),
    .sample   (sck_rise),
    .sdi      (sdi),
    .all_zero (all_zero),
    .all_one  (all_one)
  );

  sfm_frame_judge #(.CNT_W(CNT_W)) u_judge (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_end    (frame_end),
    .count        (edge_cnt),
    .want         (want_edges),
    .code_valid   (code_valid),
    .all_zero     (all_zero),
    .all_one      (all_one),
    .frame_ok     (frame_ok),
    .comm_err     (comm_err),
    .fail_safe    (fail_safe),
    .len_err_flag (len_err_flag)
  );

endmodule

// File: rtl/sfm_checker.sv
module sfm_checker (
  input logic clk,
  input logic rst_n,
  input logic csn,
  input logic frame_ok,
  input logic comm_err,
  input logic fail_safe,
  input logic len_err_flag
);

  logic any_pulse;
  assign any_pulse = frame_ok || comm_err || fail_safe;

  p_ok_not_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> !comm_err);

  p_ok_not_stuck_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> !fail_safe);

  p_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_pulse |=> !any_pulse);

  p_after_select_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_pulse |-> $past(csn));

  p_quiet_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(csn) && $past(csn, 2)) |-> !any_pulse);

  p_err_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    comm_err |-> len_err_flag);

  p_ok_clears_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> !len_err_flag);

endmodule

bind spi_frame_monitor sfm_checker u_sfm_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .csn          (csn),
  .frame_ok     (frame_ok),
  .comm_err     (comm_err),
  .fail_safe    (fail_safe),
  .len_err_flag (len_err_flag)
);

// File: tb/tb_spi_frame_monitor.sv
module tb_spi_frame_monitor;

  logic       clk;
  logic       rst_n;
  logic       sck;
  logic       csn;
  logic       sdi;
  logic [2:0] width_code;
  logic       frame_ok, comm_err, fail_safe, len_err_flag, pad_zero;

  int total;
  int bad;

  typedef struct {
    bit    ok;
    bit    err;
    bit    fs;
    bit    sticky;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  bit   model_sticky;

  spi_frame_monitor dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .sck          (sck),
    .csn          (csn),
    .sdi          (sdi),
    .width_code   (width_code),
    .frame_ok     (frame_ok),
    .comm_err     (comm_err),
    .fail_safe    (fail_safe),
    .len_err_flag (len_err_flag),
    .pad_zero     (pad_zero)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int periods_of(input logic [2:0] code);
    case (code)
      3'b001:  return 16;
      3'b010:  return 24;
      3'b100:  return 32;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit cond, input string tag, input string what,
                       input int act, input int expv);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // Driver: one frame of n clock periods, MSB first from data; pushes the expected verdict.
  task automatic send_frame(input logic [2:0] code, input int n,
                            input logic [127:0] data, input string tag);
    int   w;
    bit   zeros, ones, len_ok, stuck;
    exp_t e;
    w     = periods_of(code);
    zeros = 1'b1;
    ones  = 1'b1;
    width_code = code;
    @(negedge clk);
    csn = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = data[n-1-i];
      zeros = zeros && !sdi;
      ones  = ones && sdi;
      sck = 1'b1;
      repeat (2) @(negedge clk);
      sck = 1'b0;
      repeat (2) @(negedge clk);
      // R6 / R8: pad flag after each full period
      check(pad_zero == ((w != 0) && (i + 1 >= w)), tag, "pad_zero R6",
            int'(pad_zero), int'((w != 0) && (i + 1 >= w)));
    end
    sdi = 1'b0;
    repeat (2) @(negedge clk);
    len_ok = (w != 0) && (n == w);
    stuck  = (n > 0) && (zeros || ones);
    e.ok  = (n > 0) && len_ok && !stuck;
    e.err = (n > 0) && !len_ok;
    e.fs  = stuck;
    if (n > 0) model_sticky = !len_ok;
    e.sticky = model_sticky;
    e.tag = tag;
    exp_q.push_back(e);
    csn = 1'b1;
    repeat (6) @(negedge clk);
    // R6: pad is low with select high
    check(pad_zero == 1'b0, tag, "pad_zero idle R6", int'(pad_zero), 0);
  endtask

  // Monitor: detect the select rise at a clock edge, compare at the following negedge.
  logic mon_prev, arm;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_prev <= 1'b1;
      arm      <= 1'b0;
    end else begin
      arm      <= csn && !mon_prev;
      mon_prev <= csn;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (arm) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          check(1'b0, "R5", "unexpected frame end", 1, 0);
        end else begin
          e = exp_q.pop_front();
          check(frame_ok == e.ok, e.tag, "frame_ok", int'(frame_ok), int'(e.ok));
          check(comm_err == e.err, e.tag, "comm_err", int'(comm_err), int'(e.err));
          check(fail_safe == e.fs, e.tag, "fail_safe", int'(fail_safe), int'(e.fs));
          check(len_err_flag == e.sticky, e.tag, "len_err_flag R7",
                int'(len_err_flag), int'(e.sticky));
        end
      end else if (frame_ok || comm_err || fail_safe) begin
        // R5: pulses only in the cycle after the select rise
        check(1'b0, "R5", "stray pulse", int'({frame_ok, comm_err, fail_safe}), 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0;
    bad   = 0;
    model_sticky = 1'b0;
    rst_n = 1'b0;
    sck   = 1'b0;
    csn   = 1'b1;
    sdi   = 1'b0;
    width_code = 3'b001;
    repeat (4) @(negedge clk);
    check({frame_ok, comm_err, fail_safe, len_err_flag, pad_zero} == 5'b0,
          "R10", "outputs in reset", int'({frame_ok, comm_err, fail_safe, len_err_flag, pad_zero}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({frame_ok, comm_err, fail_safe, len_err_flag, pad_zero} == 5'b0,
          "R10", "outputs after reset", int'({frame_ok, comm_err, fail_safe, len_err_flag, pad_zero}), 0);

    send_frame(3'b001, 16, 128'hA55A, "R1 p16");
    send_frame(3'b010, 24, 128'h3C_0F81, "R1 p24");
    send_frame(3'b100, 32, 128'h8000_0001, "R1 p32");

    send_frame(3'b010, 16, 128'h7E12, "R2 short at p24");
    // R4: select low without clock leaves everything unchanged
    send_frame(3'b010, 0, 128'h0, "R4 no clock");
    send_frame(3'b010, 24, 128'h12_3456, "R7 clear by good length");

    send_frame(3'b001, 20, 128'h9_6A5C, "R2 long at p16");
    send_frame(3'b100, 31, 128'h5555_5555, "R2 one short at p32");

    send_frame(3'b001, 16, 128'h0000, "R3 all zero");
    send_frame(3'b010, 24, 128'hFF_FFFF, "R3 all one");
    send_frame(3'b001, 12, 128'hFFF, "R3 stuck and short");
    send_frame(3'b001, 16, 128'h0000, "R7 stuck clears flag");
    send_frame(3'b001, 1, 128'h1, "R3 single bit");

    send_frame(3'b011, 16, 128'hC3A5, "R8 bad code");
    send_frame(3'b000, 24, 128'h1_2345, "R8 zero code");

    send_frame(3'b100, 96, 128'h5A5A_5A5A_5A5A_5A5A_5A5A_5A5A, "R9 saturate");
    send_frame(3'b100, 32, 128'hDEAD_BEEF, "R1 recover p32");

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R5", "missing verdicts", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule